// File: doc/BRIEF.md
# Recurrent spiking reservoir array

This block is a small recurrent network of leaky integrate-and-fire neurons used as a fixed, untrained reservoir. Eight neurons sit in three groups of three, two and three. Each neuron owns two synapse units, sixteen synapses in all. The first synapse of every neuron listens to an external binary spike line. The second listens to a delayed copy of a spike from a neuron in the previous group, so the groups form a closed ring. The synapses use no multipliers. Each one counts its incoming spikes and qualifies every few of them. A qualified spike adds a fixed positive step to the membrane when the shared pseudo-random value is below the synapse's stored weight, and a fixed negative step when it is not.

The whole array advances one time step when `step_en` is high for one clock. There is no sequencer: every neuron, counter, delay register and the random generator update together on that strobe. The eight membrane potentials (signed fixed point, 12 fraction bits) form the reservoir state. They are exported with the spike vector for an off-block readout.

Top module: `rsv_array`

## Requirements
- R1: A synchronous active-high `rst` sets every membrane to the rest level 4, clears all spikes, synapse counters and delay registers, and loads the random generator with the nonzero seed 1.
- R2: While `step_en` is low, `membrane_o` and `spike_o` hold their values, whatever `ext_spk_i` does.
- R3: The random generator is a 6-bit shift register that advances only on `step_en`, from q to {q[4:0], q[5]^q[4]}. In a step, the synapses compare its low 4 bits as they were before that step's advance.
- R4: Each synapse counts the spikes on its input. Only every PULSE_DIV-th spike (default 2) is qualified, and the counter then restarts. Counting continues while the neuron is refractory.
- R5: A qualified spike contributes +512 when the random low bits are strictly less than the synapse's 5-bit weight, and −512 otherwise. An unqualified or absent spike contributes 0. Synapse s of neuron n holds weight (W_A·n + W_B·s + W_C) mod 17, with defaults W_A=5, W_B=9, W_C=3.
- R6: On a step, a non-refractory neuron computes v' = v − ((v − 4) >>> 3) + c0 + c1, where >>> is an arithmetic shift that rounds toward minus infinity.
- R7: If v' ≥ 614, the neuron emits a spike for that step and its membrane becomes 4.
- R8: On the step after a spike, the neuron is refractory: the membrane stays 4, it emits no spike, and its synapse contributions are dropped.
- R9: A membrane that would fall below −2048 is clamped to −2048.
- R10: Synapse 0 of neuron n reads `ext_spk_i[n mod 3]`. Synapse 1 reads a delay register that holds spikes from two steps earlier. Its source neuron is 0←5, 1←6, 2←7, 3←0, 4←1, 5←3, 6←4, 7←3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | One-cycle strobe that advances the network one time step |
| ext_spk_i | input | 3 | External binary spike inputs, sampled on the step |
| spike_o | output | 8 | Registered spike of each neuron for the latest step |
| membrane_o | output | 144 | Eight registered 18-bit signed membranes, neuron n in bits [18n+17:18n] |

## Verification
Membranes and spikes change on the clock edge where `step_en` is high. The bench raises the strobe for one cycle at a falling edge and samples at the next falling edge, one edge after the update. A feedback spike reaches its target synapse two steps after it fires, so the checks on the ring compare the spike vector two strobes after the firing step. Hold behaviour is checked after several idle cycles with changed external inputs. The bench also runs a reference model and compares all three parameter sets (default, all-inhibitory and all-excitatory) after every step.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // group index of neuron n for group sizes g0,g1,(rest)
    function automatic int grp_of(int n, int g0, int g1);
        if (n < g0) return 0;
        if (n < g0 + g1) return 1;
        return 2;
    endfunction

    function automatic int grp_base(int g, int g0, int g1);
        if (g == 0) return 0;
        if (g == 1) return g0;
        return g0 + g1;
    endfunction

    function automatic int grp_size(int g, int g0, int g1, int g2);
        if (g == 0) return g0;
        if (g == 1) return g1;
        return g2;
    endfunction

    // feedback source: same position (wrapped) in the previous group of the ring
    function automatic int fb_src(int n, int g0, int g1, int g2);
        int g;
        int p;
        g = grp_of(n, g0, g1);
        p = (g + 2) % 3;
        return grp_base(p, g0, g1) + ((n - grp_base(g, g0, g1)) % grp_size(p, g0, g1, g2));
    endfunction

    function automatic int syn_weight(int n, int s, int a, int b, int c, int wmax);
        return (a * n + b * s + c) % (wmax + 1);
    endfunction

endpackage

// File: rtl/rsv_lfsr.sv
module rsv_lfsr #(
    parameter int W     = 6,
    parameter int SEED  = 1,
    parameter int OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    output logic [OUT_W-1:0] rnd_o
);
    localparam logic [W-1:0] SEED_V = ((SEED % (1 << W)) == 0) ? W'(1) : W'(SEED);

    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_t;

    lfsr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_en) begin
            st_d.sr = {st_q.sr[W-2:0], st_q.sr[W-1] ^ st_q.sr[W-2]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{sr: SEED_V};
        else     st_q <= st_d;
    end

    assign rnd_o = st_q.sr[OUT_W-1:0];

    // R3
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.sr != '0);

    // R3
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(st_q.sr));

endmodule

// File: rtl/rsv_synapse.sv
module rsv_synapse #(
    parameter int               CMP_W     = 4,
    parameter int               WGT_W     = 5,
    parameter logic [WGT_W-1:0] WEIGHT    = '0,
    parameter int               PULSE_DIV = 2,
    parameter int               ACC_W     = 20,
    parameter int               SYN_STEP  = 512
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_en,
    input  logic                    spk_i,
    input  logic [CMP_W-1:0]        rnd_i,
    output logic signed [ACC_W-1:0] contrib_o
);
    localparam int CNT_W = (PULSE_DIV > 1) ? $clog2(PULSE_DIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [WGT_W-1:0] wgt;
    } syn_t;

    syn_t st_d, st_q;
    logic qual;
    logic hit;

    always_comb begin
        st_d = st_q;
        qual = spk_i && (int'(st_q.cnt) == PULSE_DIV - 1);
        hit  = WGT_W'(rnd_i) < st_q.wgt;
        if (qual) contrib_o = hit ? ACC_W'(SYN_STEP) : -ACC_W'(SYN_STEP);
        else      contrib_o = '0;
        if (step_en && spk_i) begin
            st_d.cnt = qual ? '0 : CNT_W'(st_q.cnt + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{cnt: '0, wgt: WEIGHT};
        else     st_q <= st_d;
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(st_q.cnt) < PULSE_DIV);

    // R5
    wgt_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.wgt == WEIGHT);

endmodule

// File: rtl/rsv_neuron.sv
module rsv_neuron #(
    parameter int                 MEM_W     = 18,
    parameter int                 ACC_W     = 20,
    parameter int                 CMP_W     = 4,
    parameter int                 WGT_W     = 5,
    parameter logic [2*WGT_W-1:0] WGTS      = '0,
    parameter int                 PULSE_DIV = 2,
    parameter int                 SYN_STEP  = 512,
    parameter int                 VTH       = 614,
    parameter int                 VRST      = 4,
    parameter int                 VMIN      = -2048,
    parameter int                 LEAK_SH   = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_en,
    input  logic [1:0]              syn_spk_i,
    input  logic [CMP_W-1:0]        rnd_i,
    output logic signed [MEM_W-1:0] mem_o,
    output logic                    spike_o
);
    localparam int NSYN = 2;

    typedef struct packed {
        logic [MEM_W-1:0] mem;
        logic             spike;
        logic             refr;
    } nrn_t;

    nrn_t st_d, st_q;

    logic signed [ACC_W-1:0] contrib [NSYN];
    logic signed [MEM_W-1:0] mem_cur;
    logic signed [ACC_W-1:0] mem_ext;
    logic signed [ACC_W-1:0] leak;
    logic signed [ACC_W-1:0] v_next;

    for (genvar s = 0; s < NSYN; s++) begin : g_syn
        rsv_synapse #(
            .CMP_W    (CMP_W),
            .WGT_W    (WGT_W),
            .WEIGHT   (WGTS[s*WGT_W +: WGT_W]),
            .PULSE_DIV(PULSE_DIV),
            .ACC_W    (ACC_W),
            .SYN_STEP (SYN_STEP)
        ) u_syn (
            .clk      (clk),
            .rst      (rst),
            .step_en  (step_en),
            .spk_i    (syn_spk_i[s]),
            .rnd_i    (rnd_i),
            .contrib_o(contrib[s])
        );
    end

    always_comb begin
        st_d    = st_q;
        mem_cur = st_q.mem;
        mem_ext = ACC_W'(mem_cur);
        leak    = (mem_ext - ACC_W'(VRST)) >>> LEAK_SH;
        v_next  = mem_ext - leak + contrib[0] + contrib[1];
        if (step_en) begin
            if (st_q.refr) begin
                st_d.mem   = MEM_W'(VRST);
                st_d.spike = 1'b0;
                st_d.refr  = 1'b0;
            end else if (v_next >= ACC_W'(VTH)) begin
                st_d.mem   = MEM_W'(VRST);
                st_d.spike = 1'b1;
                st_d.refr  = 1'b1;
            end else begin
                st_d.mem   = (v_next < ACC_W'(VMIN)) ? MEM_W'(VMIN) : MEM_W'(v_next);
                st_d.spike = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{mem: MEM_W'(VRST), spike: 1'b0, refr: 1'b0};
        else     st_q <= st_d;
    end

    assign mem_o   = st_q.mem;
    assign spike_o = st_q.spike;

    // R7
    fire_reset_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.spike |-> (mem_o == MEM_W'(VRST)));

    // R8
    refr_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && st_q.spike) |=> !spike_o);

    // R9
    floor_chk: assert property (@(posedge clk) disable iff (rst)
        mem_o >= MEM_W'(VMIN));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> ($stable(mem_o) && $stable(spike_o)));

endmodule

// File: rtl/rsv_array.sv
module rsv_array #(
    parameter int N_IN      = 3,
    parameter int G0        = 3,
    parameter int G1        = 2,
    parameter int G2        = 3,
    parameter int MEM_W     = 18,
    parameter int RND_W     = 6,
    parameter int CMP_W     = 4,
    parameter int RND_SEED  = 1,
    parameter int PULSE_DIV = 2,
    parameter int W_A       = 5,
    parameter int W_B       = 9,
    parameter int W_C       = 3,
    parameter int SYN_STEP  = 512,
    parameter int VTH       = 614,
    parameter int VRST      = 4,
    parameter int VMIN      = -2048,
    parameter int LEAK_SH   = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   step_en,
    input  logic [N_IN-1:0]        ext_spk_i,
    output logic [G0+G1+G2-1:0]    spike_o,
    output logic [(G0+G1+G2)*MEM_W-1:0] membrane_o
);
    localparam int N     = G0 + G1 + G2;
    localparam int WGT_W = CMP_W + 1;
    localparam int WMAX  = 1 << CMP_W;
    localparam int ACC_W = MEM_W + 2;

    typedef struct packed {
        logic [N-1:0] dly;
    } top_t;

    top_t st_d, st_q;
    logic [CMP_W-1:0] rnd;

    rsv_lfsr #(
        .W    (RND_W),
        .SEED (RND_SEED),
        .OUT_W(CMP_W)
    ) u_lfsr (
        .clk    (clk),
        .rst    (rst),
        .step_en(step_en),
        .rnd_o  (rnd)
    );

    always_comb begin
        st_d = st_q;
        if (step_en) st_d.dly = spike_o;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{dly: '0};
        else     st_q <= st_d;
    end

    for (genvar n = 0; n < N; n++) begin : g_nrn
        localparam int SRC = rsv_pkg::fb_src(n, G0, G1, G2);
        localparam int W0  = rsv_pkg::syn_weight(n, 0, W_A, W_B, W_C, WMAX);
        localparam int W1  = rsv_pkg::syn_weight(n, 1, W_A, W_B, W_C, WMAX);
        localparam logic [2*WGT_W-1:0] WV = {WGT_W'(W1), WGT_W'(W0)};

        logic [1:0]              nrn_spk;
        logic signed [MEM_W-1:0] nrn_mem;
        logic                    nrn_fire;

        assign nrn_spk = {st_q.dly[SRC], ext_spk_i[n % N_IN]};

        rsv_neuron #(
            .MEM_W    (MEM_W),
            .ACC_W    (ACC_W),
            .CMP_W    (CMP_W),
            .WGT_W    (WGT_W),
            .WGTS     (WV),
            .PULSE_DIV(PULSE_DIV),
            .SYN_STEP (SYN_STEP),
            .VTH      (VTH),
            .VRST     (VRST),
            .VMIN     (VMIN),
            .LEAK_SH  (LEAK_SH)
        ) u_nrn (
            .clk      (clk),
            .rst      (rst),
            .step_en  (step_en),
            .syn_spk_i(nrn_spk),
            .rnd_i    (rnd),
            .mem_o    (nrn_mem),
            .spike_o  (nrn_fire)
        );

        assign spike_o[n]                    = nrn_fire;
        assign membrane_o[n*MEM_W +: MEM_W] = nrn_mem;
    end

    // R10
    dly_load_chk: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (st_q.dly == $past(spike_o)));

    // R10
    dly_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(st_q.dly));

endmodule

// File: tb/rsv_array_tb_top.sv
`timescale 1ns/1ps
module rsv_array_tb_top;
    localparam int N  = 8;
    localparam int MW = 18;
    localparam int NSTEP = 32;

    // main-instance external spike pattern per step
    localparam logic [2:0] STIM [NSTEP] = '{
        3'b001, 3'b001, 3'b011, 3'b111, 3'b110, 3'b111, 3'b101, 3'b111,
        3'b010, 3'b111, 3'b111, 3'b100, 3'b011, 3'b111, 3'b000, 3'b111,
        3'b111, 3'b101, 3'b110, 3'b111, 3'b011, 3'b111, 3'b001, 3'b111,
        3'b111, 3'b010, 3'b111, 3'b100, 3'b111, 3'b111, 3'b011, 3'b110
    };

    // per-instance parameters: 0 default, 1 all-inhibitory, 2 all-excitatory
    localparam int PD [3] = '{2, 1, 1};
    localparam int WA [3] = '{5, 0, 0};
    localparam int WB [3] = '{9, 0, 0};
    localparam int WC [3] = '{3, 0, 16};
    localparam int SRC [N] = '{5, 6, 7, 0, 1, 3, 4, 3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_en = 1'b0;
    logic [2:0] ext_main = '0;
    logic [2:0] ext_aux  = 3'b111;
    logic [N-1:0] spk0, spk1, spk2;
    logic [N*MW-1:0] mem0, mem1, mem2;

    int n_tests = 0;
    int n_fail  = 0;

    int m_lfsr [3];
    int m_cnt  [3][N][2];
    int m_mem  [3][N];
    int m_spk  [3][N];
    int m_refr [3][N];
    int m_dly  [3][N];

    always #10 clk = ~clk;

    rsv_array dut_i (
        .clk(clk), .rst(rst), .step_en(step_en), .ext_spk_i(ext_main),
        .spike_o(spk0), .membrane_o(mem0)
    );

    rsv_array #(.PULSE_DIV(1), .W_A(0), .W_B(0), .W_C(0)) dut_inh_i (
        .clk(clk), .rst(rst), .step_en(step_en), .ext_spk_i(ext_aux),
        .spike_o(spk1), .membrane_o(mem1)
    );

    rsv_array #(.PULSE_DIV(1), .W_A(0), .W_B(0), .W_C(16)) dut_exc_i (
        .clk(clk), .rst(rst), .step_en(step_en), .ext_spk_i(ext_aux),
        .spike_o(spk2), .membrane_o(mem2)
    );

    function automatic int mem_at(logic [N*MW-1:0] v, int n);
        return int'($signed(v[n*MW +: MW]));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 3; k++) begin
            m_lfsr[k] = 1;
            for (int n = 0; n < N; n++) begin
                m_mem[k][n] = 4; m_spk[k][n] = 0; m_refr[k][n] = 0; m_dly[k][n] = 0;
                m_cnt[k][n][0] = 0; m_cnt[k][n][1] = 0;
            end
        end
    endtask

    task automatic model_step(int k, logic [2:0] ext);
        int rnd;
        int nm [N];
        int ns [N];
        int nr [N];
        rnd = m_lfsr[k] & 15;
        for (int n = 0; n < N; n++) begin
            int sum;
            int lk;
            int v;
            sum = 0;
            for (int s = 0; s < 2; s++) begin
                int sin;
                sin = (s == 0) ? int'(ext[n % 3]) : m_dly[k][SRC[n]];
                if (sin != 0) begin
                    if (m_cnt[k][n][s] == PD[k] - 1) begin
                        int w;
                        w = (WA[k] * n + WB[k] * s + WC[k]) % 17;
                        sum += (rnd < w) ? 512 : -512;
                        m_cnt[k][n][s] = 0;
                    end else begin
                        m_cnt[k][n][s]++;
                    end
                end
            end
            if (m_refr[k][n] != 0) begin
                nm[n] = 4; ns[n] = 0; nr[n] = 0;
            end else begin
                lk = (m_mem[k][n] - 4) >>> 3;
                v  = m_mem[k][n] - lk + sum;
                if (v >= 614) begin
                    nm[n] = 4; ns[n] = 1; nr[n] = 1;
                end else begin
                    nm[n] = (v < -2048) ? -2048 : v; ns[n] = 0; nr[n] = 0;
                end
            end
        end
        for (int n = 0; n < N; n++) begin
            m_dly[k][n] = m_spk[k][n];
            m_spk[k][n] = ns[n]; m_mem[k][n] = nm[n]; m_refr[k][n] = nr[n];
        end
        m_lfsr[k] = ((m_lfsr[k] << 1) & 63) | (((m_lfsr[k] >> 5) ^ (m_lfsr[k] >> 4)) & 1);
    endtask

    function automatic int m_spkvec(int k);
        int r;
        r = 0;
        for (int n = 0; n < N; n++) r |= m_spk[k][n] << n;
        return r;
    endfunction

    task automatic cmp_all(string req);
        for (int n = 0; n < N; n++) begin
            chk({req, " inst0 membrane"}, mem_at(mem0, n), m_mem[0][n]);
            chk({req, " inst1 membrane"}, mem_at(mem1, n), m_mem[1][n]);
            chk({req, " inst2 membrane"}, mem_at(mem2, n), m_mem[2][n]);
        end
        chk({req, " inst0 spikes"}, int'(spk0), m_spkvec(0));
        chk({req, " inst1 spikes"}, int'(spk1), m_spkvec(1));
        chk({req, " inst2 spikes"}, int'(spk2), m_spkvec(2));
    endtask

    task automatic do_step(logic [2:0] e);
        @(negedge clk);
        ext_main = e;
        step_en  = 1'b1;
        @(negedge clk);
        step_en  = 1'b0;
        model_step(0, e);
        model_step(1, 3'b111);
        model_step(2, 3'b111);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state on all instances
        for (int n = 0; n < N; n++) begin
            chk("R1 reset membrane inst0", mem_at(mem0, n), 4);
            chk("R1 reset membrane inst1", mem_at(mem1, n), 4);
            chk("R1 reset membrane inst2", mem_at(mem2, n), 4);
        end
        chk("R1 reset spikes", int'(spk0 | spk1 | spk2), 0);

        for (int i = 0; i < NSTEP; i++) begin
            do_step(STIM[i]);
            cmp_all("R3 R4 R5 R6 R7 R10 model");
            if (i == 0) begin
                chk("R4 first spike unqualified", mem_at(mem0, 0), 4);
                chk("R5 R6 excitatory step", mem_at(mem2, 0), 516);
                chk("R5 inhibitory step", mem_at(mem1, 0), -508);
            end
            if (i == 1) begin
                chk("R7 all fire", int'(spk2), 8'hFF);
                chk("R7 membrane to rest", mem_at(mem2, 4), 4);
            end
            if (i == 2) begin
                chk("R8 refractory no spike", int'(spk2), 0);
                chk("R8 refractory membrane", mem_at(mem2, 7), 4);
            end
            if (i == 3) chk("R10 feedback two steps later", int'(spk2), 8'hFF);
            if (i == 5) chk("R9 floor clamp", mem_at(mem1, 0), -2048);
            if (i == 7) chk("R9 floor held", mem_at(mem1, 3), -2048);
            if (i == 10) begin
                // R2: idle cycles with toggling inputs must not move anything
                for (int c = 0; c < 4; c++) begin
                    @(negedge clk);
                    ext_main = 3'(c + 5);
                end
                cmp_all("R2 hold without step");
            end
        end

        // mid-run reset returns to the known state
        do_reset();
        for (int n = 0; n < N; n++) chk("R1 second reset", mem_at(mem0, n), 4);
        chk("R1 second reset spikes", int'(spk0), 0);
        do_step(3'b001);
        chk("R4 counter restarted by reset", mem_at(mem0, 0), 4);
        cmp_all("R3 R4 after reset model");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule